// File: doc/BRIEF.md
# Debug Configuration Register Bank with Arm Lock

This block is the byte-wide register file of an on-chip debug unit. It holds one main control register and four comparator configuration banks. All four banks share a single 8-byte address window, and a two-bit bank-select field in the control register picks which bank that window reaches. A simple synchronous bus drives the block: an address, a write strobe and write data are sampled on the clock edge, and read data is a combinational function of the address.

Setting the arm bit freezes the configuration. While the unit is armed, only the arm bit, the bank selector and the write-only trigger bit still respond to writes. Every other field and every comparator byte ignores writes. The lock is judged from the arm state held before the write. A write that clears arm therefore does not change the locked fields, and a second write is needed to change them. Writing 1 to the trigger bit produces a one-cycle pulse and is never stored. All decoded fields are driven out so that the matching logic elsewhere can use them.

Top module: `dbgreg_top`

## Requirements
- R1: After reset, the control register and every comparator byte are 0x00, all field outputs are 0, and `dbg_trig` is low.
- R2: A read of offset 0x20 returns arm in bit 7, the three enable fields in bits 5:3 (bit 5 `copro_bp_en`, bit 4 `monitor_en`, bit 3 `brk_en`) and the bank selector in bits 1:0. Bits 6 and 2 always read 0, and bit 2 ignores writes.
- R3: A write to 0x20 with bit 6 set drives `dbg_trig` high for exactly the cycle that follows the write edge. This holds whether or not the unit is armed, and the bit is not stored.
- R4: Writes to 0x20 always update arm (bit 7) and the bank selector (bits 1:0), in either arm state.
- R5: Bits 5:3 of 0x20 take the written value only when arm was 0 before the write. A write that clears arm leaves them unchanged.
- R6: Offsets 0x28 to 0x2F address bytes 0 to 7 of the bank picked by the selector (0 to 3 select banks 0 to 3). Reads and writes reach only that bank, and the other banks keep their contents.
- R7: While arm is 1, writes to 0x28 to 0x2F are ignored. After disarming, such writes take effect again.
- R8: For bank k, `cmp_ctl[8k+:8]` is byte 0, `cmp_addr[24k+:24]` is {byte 1, byte 2, byte 3}, `cmp_data[16k+:16]` is {byte 4, byte 5} and `cmp_mask[16k+:16]` is {byte 6, byte 7}. The enable outputs and the selector mirror the control fields.
- R9: Reads of any other offset return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| dbg_armed | output | 1 | Arm bit |
| dbg_trig | output | 1 | One-cycle trigger pulse |
| copro_bp_en | output | 1 | Control bit 5 |
| monitor_en | output | 1 | Control bit 4 |
| brk_en | output | 1 | Control bit 3 |
| bank_sel | output | 2 | Selected comparator bank |
| cmp_ctl | output | 32 | Control byte of each bank |
| cmp_addr | output | 96 | 24-bit address of each bank |
| cmp_data | output | 64 | 16-bit compare data of each bank |
| cmp_mask | output | 64 | 16-bit data mask of each bank |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are stable around each clock edge and never unknown once reset is released. They also assume that the write strobe lasts one cycle per intended write, so that every write edge counts as exactly one register update. The stimulus drives the bus just after each rising edge and holds it steady until the next one. It never leaves the write strobe high while the address changes, and it keeps the strobe low during reset. Read-back comparisons happen at the falling edge, where the combinational read path has settled.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned MID_W     = 3;
  localparam int unsigned CTL_OFS   = 32'h20;
  localparam int unsigned WIN_BASE  = 32'h28;
  localparam int unsigned WIN_BYTES = 8;
  localparam int unsigned IDX_W     = $clog2(WIN_BYTES);

  // control byte bit positions
  localparam int unsigned B_ARM    = 7;
  localparam int unsigned B_TRIG   = 6;
  localparam int unsigned B_MID_HI = 5;
  localparam int unsigned B_MID_LO = 3;
  localparam int unsigned B_RSV    = 2;
  localparam int unsigned B_SEL_HI = 1;

  // window byte indices
  localparam int unsigned W_CTL   = 0;
  localparam int unsigned W_AHI   = 1;
  localparam int unsigned W_AMID  = 2;
  localparam int unsigned W_ALO   = 3;
  localparam int unsigned W_DHI   = 4;
  localparam int unsigned W_DLO   = 5;
  localparam int unsigned W_MHI   = 6;
  localparam int unsigned W_MLO   = 7;

  // lock rule: the enable field follows the write only when unarmed before it
  function automatic logic [MID_W-1:0] mid_next(input logic [MID_W-1:0] old_mid,
                                                input logic arm_before,
                                                input logic [BYTE_W-1:0] wdata);
    return arm_before ? old_mid : wdata[B_MID_HI:B_MID_LO];
  endfunction

  // read image of the control byte; trigger and reserved bits read 0
  function automatic logic [BYTE_W-1:0] ctl_image(input logic arm,
                                                  input logic [MID_W-1:0] mid,
                                                  input logic [SEL_W-1:0] sel);
    return {arm, 1'b0, mid, 1'b0, sel};
  endfunction
endpackage

// File: rtl/dbgreg_decode.sv
module dbgreg_decode
  import dbgreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit_ctl,
  output logic              hit_win,
  output logic [IDX_W-1:0]  win_idx,
  output logic              ctl_wr,
  output logic              win_wr
);
  logic [ADDR_W-1:0] rel;

  assign rel     = addr - ADDR_W'(WIN_BASE);
  assign hit_ctl = (addr == ADDR_W'(CTL_OFS));
  assign hit_win = (rel < ADDR_W'(WIN_BYTES));
  assign win_idx = rel[IDX_W-1:0];
  assign ctl_wr  = we && hit_ctl;
  assign win_wr  = we && hit_win;
endmodule

// File: rtl/dbgreg_ctl.sv
module dbgreg_ctl
  import dbgreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              armed,
  output logic [MID_W-1:0]  mid,
  output logic [SEL_W-1:0]  sel,
  output logic              trig_pulse,
  output logic [BYTE_W-1:0] rd_byte
);
  logic             arm_q;
  logic [MID_W-1:0] mid_q;
  logic [SEL_W-1:0] sel_q;
  logic             trig_q;
  logic             unused_rsv;

  assign unused_rsv = wdata[B_RSV];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      mid_q  <= '0;
      sel_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= ctl_wr && wdata[B_TRIG];
      if (ctl_wr) begin
        arm_q <= wdata[B_ARM];
        sel_q <= wdata[B_SEL_HI:0];
        mid_q <= mid_next(mid_q, arm_q, wdata);
      end
    end
  end

  assign armed      = arm_q;
  assign mid        = mid_q;
  assign sel        = sel_q;
  assign trig_pulse = trig_q;
  assign rd_byte    = ctl_image(arm_q, mid_q, sel_q);

  // R5: an armed write never alters the enable field
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && ctl_wr) |=> $stable(mid_q));

  // R4: arm and selector follow every control write
  p_free_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (arm_q == $past(wdata[B_ARM])) && (sel_q == $past(wdata[B_SEL_HI:0])));

  // R3: a pulse is always caused by a trigger write on the previous edge
  p_trig_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(ctl_wr && wdata[B_TRIG]));
endmodule

// File: rtl/dbgreg_bank.sv
module dbgreg_bank
  import dbgreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] f_ctl,
  output logic [3*BYTE_W-1:0] f_addr,
  output logic [2*BYTE_W-1:0] f_data,
  output logic [2*BYTE_W-1:0] f_mask
);
  logic [WIN_BYTES-1:0][BYTE_W-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rd_byte = mem_q[idx];
  assign f_ctl   = mem_q[W_CTL];
  assign f_addr  = {mem_q[W_AHI], mem_q[W_AMID], mem_q[W_ALO]};
  assign f_data  = {mem_q[W_DHI], mem_q[W_DLO]};
  assign f_mask  = {mem_q[W_MHI], mem_q[W_MLO]};

  // R6: a bank that is not written keeps every byte
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/dbgreg_top.sv
module dbgreg_top
  import dbgreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [BYTE_W-1:0]             bus_wdata,
  output logic [BYTE_W-1:0]             bus_rdata,
  output logic                          dbg_armed,
  output logic                          dbg_trig,
  output logic                          copro_bp_en,
  output logic                          monitor_en,
  output logic                          brk_en,
  output logic [SEL_W-1:0]              bank_sel,
  output logic [NUM_BANKS*BYTE_W-1:0]   cmp_ctl,
  output logic [NUM_BANKS*3*BYTE_W-1:0] cmp_addr,
  output logic [NUM_BANKS*2*BYTE_W-1:0] cmp_data,
  output logic [NUM_BANKS*2*BYTE_W-1:0] cmp_mask
);
  logic              hit_ctl, hit_win, ctl_wr, win_wr;
  logic [IDX_W-1:0]  win_idx;
  logic [MID_W-1:0]  mid;
  logic [SEL_W-1:0]  sel;
  logic              armed;
  logic [BYTE_W-1:0] ctl_rd;
  logic [BYTE_W-1:0] bank_rd [NUM_BANKS];
  logic [BYTE_W-1:0] win_rd;

  dbgreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .hit_ctl(hit_ctl), .hit_win(hit_win),
    .win_idx(win_idx), .ctl_wr(ctl_wr), .win_wr(win_wr)
  );

  dbgreg_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(bus_wdata),
    .armed(armed), .mid(mid), .sel(sel), .trig_pulse(dbg_trig), .rd_byte(ctl_rd)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic bank_wr;
    assign bank_wr = win_wr && !armed && (sel == SEL_W'(k));
    dbgreg_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .idx(win_idx), .wdata(bus_wdata),
      .rd_byte(bank_rd[k]),
      .f_ctl (cmp_ctl [k*BYTE_W   +: BYTE_W]),
      .f_addr(cmp_addr[k*3*BYTE_W +: 3*BYTE_W]),
      .f_data(cmp_data[k*2*BYTE_W +: 2*BYTE_W]),
      .f_mask(cmp_mask[k*2*BYTE_W +: 2*BYTE_W])
    );
  end

  always_comb begin
    win_rd = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (sel == SEL_W'(k)) win_rd = bank_rd[k];
    end
  end

  assign bus_rdata   = hit_ctl ? ctl_rd : (hit_win ? win_rd : '0);
  assign dbg_armed   = armed;
  assign copro_bp_en = mid[2];
  assign monitor_en  = mid[1];
  assign brk_en      = mid[0];
  assign bank_sel    = sel;

  // R7: an armed window write leaves every comparator field untouched
  p_armed_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && win_wr) |=> $stable({cmp_ctl, cmp_addr, cmp_data, cmp_mask}));

  // R9: offsets outside the control byte and the window read as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ctl && !hit_win) |-> (bus_rdata == '0));

  // R2: trigger and reserved positions never read back as 1
  p_ctl_blank_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |-> (bus_rdata[B_TRIG] == 1'b0) && (bus_rdata[B_RSV] == 1'b0));
endmodule

// File: tb/dbgreg_top_test.sv
module dbgreg_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic dbg_armed, dbg_trig, copro_bp_en, monitor_en, brk_en;
  logic [1:0] bank_sel;
  logic [NB*8-1:0]  cmp_ctl;
  logic [NB*24-1:0] cmp_addr;
  logic [NB*16-1:0] cmp_data, cmp_mask;

  dbgreg_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_armed(dbg_armed),
    .dbg_trig(dbg_trig), .copro_bp_en(copro_bp_en), .monitor_en(monitor_en),
    .brk_en(brk_en), .bank_sel(bank_sel), .cmp_ctl(cmp_ctl), .cmp_addr(cmp_addr),
    .cmp_data(cmp_data), .cmp_mask(cmp_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench model, built from the requirements
  logic       m_arm = 1'b0;
  logic [2:0] m_mid = 3'b0;
  logic [1:0] m_sel = 2'b0;
  logic [7:0] m_bank [NB][8];

  // scoreboard for read-backs
  logic [7:0] exp_q [$];
  logic [7:0] adr_q [$];
  string      tag_q [$];
  logic       rd_req = 1'b0;
  logic       prev_trig_wr = 1'b0;

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pops expected read values and checks the trigger pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_trig_wr || dbg_trig) check("R3 trigger pulse", 128'(dbg_trig), 128'(prev_trig_wr));
      prev_trig_wr = bus_we && (bus_addr == 8'h20) && bus_wdata[6];
      if (rd_req) begin
        if (exp_q.size() == 0) check("scoreboard underflow", 128'd1, 128'd0);
        else begin
          logic [7:0] e, a;
          string t;
          e = exp_q.pop_front(); a = adr_q.pop_front(); t = tag_q.pop_front();
          total++;
          if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s: read %02h got %02h expected %02h", t, a, bus_rdata, e);
          end
        end
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a == 8'h20) return {m_arm, 1'b0, m_mid, 1'b0, m_sel};
    if (a >= 8'h28 && a <= 8'h2F) return m_bank[m_sel][a - 8'h28];
    return 8'h00;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    rd_req = 1'b0; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    if (a == 8'h20) begin
      if (!m_arm) m_mid = d[5:3];
      m_arm = d[7];
      m_sel = d[1:0];
    end else if (a >= 8'h28 && a <= 8'h2F && !m_arm) begin
      m_bank[m_sel][a - 8'h28] = d;
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(model_read(a)); adr_q.push_back(a); tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_we = 1'b0; rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_outputs(input string tag);
    idle();
    check({tag, " armed"}, 128'(dbg_armed), 128'(m_arm));
    check({tag, " enables"}, 128'({copro_bp_en, monitor_en, brk_en}), 128'(m_mid));
    check({tag, " bank_sel"}, 128'(bank_sel), 128'(m_sel));
    for (int k = 0; k < NB; k++) begin
      check({tag, " cmp_ctl"},  128'(cmp_ctl[k*8 +: 8]), 128'(m_bank[k][0]));
      check({tag, " cmp_addr"}, 128'(cmp_addr[k*24 +: 24]),
            128'({m_bank[k][1], m_bank[k][2], m_bank[k][3]}));
      check({tag, " cmp_data"}, 128'(cmp_data[k*16 +: 16]), 128'({m_bank[k][4], m_bank[k][5]}));
      check({tag, " cmp_mask"}, 128'(cmp_mask[k*16 +: 16]), 128'({m_bank[k][6], m_bank[k][7]}));
    end
  endtask

  task automatic read_all_banks(input string tag);
    for (int k = 0; k < NB; k++) begin
      wr(8'h20, {m_arm, 1'b0, m_mid, 1'b0, 2'(k)});
      for (int i = 0; i < 8; i++) rd(8'h28 + 8'(i), tag);
    end
  endtask

  initial begin
    for (int k = 0; k < NB; k++) for (int i = 0; i < 8; i++) m_bank[k][i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(8'h20, "R1 ctl after reset");
    for (int i = 0; i < 8; i++) rd(8'h28 + 8'(i), "R1 window after reset");
    chk_outputs("R1");
    check("R1 trig low", 128'(dbg_trig), 128'd0);

    // R2: field layout, reserved bit dropped, trigger not stored
    wr(8'h20, 8'h3F);
    rd(8'h20, "R2 ctl layout");
    chk_outputs("R8 enables");
    wr(8'h20, 8'h41);
    rd(8'h20, "R2 trig bit reads 0");

    // R6: fill each bank through the window
    for (int k = 0; k < NB; k++) begin
      wr(8'h20, 8'(k) | 8'(k << 3));
      for (int i = 0; i < 8; i++) wr(8'h28 + 8'(i), 8'((k << 4) + i + 1));
    end
    read_all_banks("R6 bank readback");
    chk_outputs("R8 comparator fields");

    // R5 / R4: arm, then try to change locked bits
    wr(8'h20, 8'hAA);
    rd(8'h20, "R4 arm set");
    wr(8'h20, 8'h91);
    rd(8'h20, "R5 locked while armed");
    chk_outputs("R4 selector armed");
    // R7: window writes ignored while armed
    wr(8'h2A, 8'hEE);
    wr(8'h2F, 8'hDD);
    rd(8'h2A, "R7 armed write ignored");
    rd(8'h2F, "R7 armed write ignored");
    chk_outputs("R7 fields frozen");
    // R3: trigger while armed
    wr(8'h20, 8'hC1);
    rd(8'h20, "R3 trig armed not stored");

    // R5: disarming write keeps locked bits, second write changes them
    wr(8'h20, 8'h38);
    rd(8'h20, "R5 disarm keeps bits");
    wr(8'h20, 8'h38);
    rd(8'h20, "R5 second write applies");
    // R7: window writable again
    wr(8'h2A, 8'h5C);
    rd(8'h2A, "R7 write after disarm");
    read_all_banks("R6 other banks kept");

    // R9: unmapped offsets
    wr(8'h24, 8'hFF);
    wr(8'h30, 8'hFF);
    rd(8'h21, "R9 unmapped");
    rd(8'h27, "R9 unmapped");
    rd(8'h00, "R9 unmapped");
    rd(8'h1F, "R9 unmapped");
    rd(8'h30, "R9 unmapped");
    rd(8'hFF, "R9 unmapped");
    rd(8'h20, "R9 ctl unchanged");
    chk_outputs("R9 fields unchanged");

    idle();
    idle();
    check("scoreboard drained", 128'(exp_q.size()), 128'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule